// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a host a narrow window of four byte locations into a much larger internal byte-addressed space. The host first writes a mode byte and two address bytes, then moves data through the fourth location. Each access through that location goes to the internal byte whose address is built from the two address bytes. The block drives an internal memory interface with an address, write data, a write strobe and a read strobe. Each strobe also tells whatever sits behind the memory that the access happened, so that logic can react to it.

Two mode bits shape the access. One bit picks which address byte supplies the high half of the internal address. The other bit makes the address step by one after every data access. After a step, the new address is split back into the two address bytes in the same order that was used to build it. A later change of byte order therefore sees the stepped value. Internal reads take one cycle, and the host gets its read result, flagged as valid, in the cycle after the read request.

Top module: `ind_port`

## Requirements
- R1: After reset the mode and both address bytes are zero, so the memory address is 0x0000, no strobe is active and no read result is flagged valid.
- R2: `host_sel` picks the location: 0 is the mode byte (bit 0 enables auto-increment, bit 1 selects byte order), 1 is address byte A, 2 is address byte B and 3 is the data window. A write to 0, 1 or 2 updates only that register.
- R3: With mode bit 1 clear the memory address is {A, B} (A is the high byte). With it set the address is {B, A}.
- R4: A host write to the data window raises `mem_we` in the same cycle, with `mem_addr` equal to the current address and `mem_wdata` equal to the host data.
- R5: A host read of the data window raises `mem_re` in the same cycle. In the next cycle `host_rvalid` is high and `host_rdata` equals `mem_rdata`.
- R6: A host read of location 0, 1 or 2 makes no memory access, and in the next cycle returns 0xFF with `host_rvalid` high.
- R7: With mode bit 0 set, each data-window read or write adds one to the address, and the new address applies from the next cycle. With the bit clear the address does not change.
- R8: After a step, the new address is written back into A and B in the byte order given by mode bit 1. Swapping the order afterwards presents the swapped stepped value.
- R9: Auto-increment wraps from 0xFFFF to 0x0000.
- R10: When `host_wr` and `host_rd` are both high, only the write takes place. No read strobe and no valid read result come from that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Location select |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_wdata | input | BYTE_W | Host write data |
| host_rdata | output | BYTE_W | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read result valid, one cycle after the request |
| mem_addr | output | 2*BYTE_W | Internal address |
| mem_wdata | output | BYTE_W | Internal write data |
| mem_we | output | 1 | Internal write strobe |
| mem_re | output | 1 | Internal read strobe |
| mem_rdata | input | BYTE_W | Internal read data, one cycle after mem_re |

## Verification
The assertions check on every cycle the rules that link one cycle to the next. The address steps by exactly one after a window access with increment on, and stays unchanged with increment off. A read request is always followed by exactly one valid cycle, a non-window read returns 0xFF, and a window read passes the memory data through. Only the bench scenarios can show the rest. These are the byte order chosen by the mode bit, the write-back of a stepped address that becomes visible after the order is swapped, the wrap at 0xFFFF, and whether data written through the window comes back at the right address.

// File: rtl/ind_port.sv
module ind_port #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          host_sel,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic [BYTE_W-1:0]   host_wdata,
  output logic [BYTE_W-1:0]   host_rdata,
  output logic                host_rvalid,
  output logic [2*BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata,
  output logic                mem_we,
  output logic                mem_re,
  input  logic [BYTE_W-1:0]   mem_rdata
);
  localparam int ADDR_W = 2 * BYTE_W;

  logic [1:0]        mode_q;
  logic [BYTE_W-1:0] ab_a_q, ab_b_q;
  logic              win_rd_q, rvalid_q;

  wire              swap    = mode_q[1];
  wire              step    = mode_q[0];
  wire              is_win  = (host_sel == 2'd3);
  wire              rd_go   = host_rd & ~host_wr;
  wire              win_acc = is_win & (host_wr | rd_go);
  wire [ADDR_W-1:0] next_addr = mem_addr + 1'b1;

  assign mem_addr    = swap ? {ab_b_q, ab_a_q} : {ab_a_q, ab_b_q};
  assign mem_wdata   = host_wdata;
  assign mem_we      = host_wr & is_win;
  assign mem_re      = rd_go & is_win;
  assign host_rvalid = rvalid_q;
  assign host_rdata  = win_rd_q ? mem_rdata : {BYTE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      ab_a_q   <= '0;
      ab_b_q   <= '0;
      rvalid_q <= 1'b0;
      win_rd_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
      win_rd_q <= rd_go & is_win;
      if (host_wr) begin
        case (host_sel)
          2'd0:    mode_q <= host_wdata[1:0];
          2'd1:    ab_a_q <= host_wdata;
          2'd2:    ab_b_q <= host_wdata;
          default: ;
        endcase
      end
      if (win_acc && step) begin
        if (swap) {ab_b_q, ab_a_q} <= next_addr;
        else      {ab_a_q, ab_b_q} <= next_addr;
      end
    end
  end
endmodule

// File: rtl/ind_port_chk.sv
module ind_port_chk #(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          host_sel,
  input logic                host_wr,
  input logic                host_rd,
  input logic [BYTE_W-1:0]   host_rdata,
  input logic                host_rvalid,
  input logic [2*BYTE_W-1:0] mem_addr,
  input logic                mem_re,
  input logic [BYTE_W-1:0]   mem_rdata,
  input logic [1:0]          mode_q
);
  wire win_acc = (host_sel == 2'd3) && (host_wr || host_rd);

  // R7
  step_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && mode_q[0]) |=> mem_addr == $past(mem_addr) + 1'b1);

  // R7
  step_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_acc && !mode_q[0]) |=> $stable(mem_addr));

  // R5
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> host_rvalid);

  // R10
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr) |=> !host_rvalid);

  // R6
  non_window_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_sel != 2'd3) |=> host_rdata == {BYTE_W{1'b1}});

  // R5
  window_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rvalid && $past(mem_re)) |-> host_rdata == mem_rdata);
endmodule

bind ind_port ind_port_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
  .host_rd(host_rd), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
  .mem_addr(mem_addr), .mem_re(mem_re), .mem_rdata(mem_rdata), .mode_q(mode_q)
);

// File: tb/ind_port_tb_top.sv
module ind_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] mem_m [int];
  logic [7:0] shadow [int];
  logic [1:0] m_mode = '0;
  logic [7:0] m_a = '0, m_b = '0;

  always #2 clk = ~clk;

  ind_port dut_i (.*);

  always @(posedge clk) begin
    if (mem_we) mem_m[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
  end

  function automatic logic [15:0] exp_addr(logic [1:0] md, logic [7:0] a, logic [7:0] b);
    return md[1] ? {b, a} : {a, b};
  endfunction

  function automatic logic [7:0] shadow_rd(logic [15:0] ad);
    return shadow.exists(int'(ad)) ? shadow[int'(ad)] : 8'h00;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(logic [1:0] sel, bit wr, bit rd, logic [7:0] d);
    logic [15:0] ea;
    bit          rdgo, acc;
    ea   = exp_addr(m_mode, m_a, m_b);
    rdgo = rd && !wr;
    acc  = (sel == 2'd3) && (wr || rdgo);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
    #1;
    chk(mem_we == (wr && sel == 2'd3), "R4 mem_we", mem_we, wr && sel == 2'd3);
    chk(mem_re == (rdgo && sel == 2'd3), "R10 mem_re", mem_re, rdgo && sel == 2'd3);
    if (acc) chk(mem_addr == ea, "R3 mem_addr", mem_addr, ea);
    if (mem_we) chk(mem_wdata == d, "R4 mem_wdata", mem_wdata, d);
    @(negedge clk);
    host_wr = 0; host_rd = 0;
    #1;
    chk(host_rvalid == rdgo, "R5 rvalid", host_rvalid, rdgo);
    if (rdgo) begin
      if (sel == 2'd3) chk(host_rdata == shadow_rd(ea), "R5 rdata", host_rdata, shadow_rd(ea));
      else             chk(host_rdata == 8'hFF, "R6 rdata", host_rdata, 8'hFF);
    end
    if (wr) begin
      case (sel)
        2'd0: m_mode = d[1:0];
        2'd1: m_a = d;
        2'd2: m_b = d;
        default: shadow[int'(ea)] = d;
      endcase
    end
    if (acc && m_mode[0]) begin
      if (m_mode[1]) {m_b, m_a} = ea + 16'd1;
      else           {m_a, m_b} = ea + 16'd1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(mem_addr == 16'h0 && !mem_we && !mem_re && !host_rvalid, "R1 reset", mem_addr, 0);
    rst_n = 1'b1;
    // R2, R3 big-end order
    op(0, 1, 0, 8'h00); op(1, 1, 0, 8'h12); op(2, 1, 0, 8'h34);
    #1; chk(mem_addr == 16'h1234, "R3 order A-high", mem_addr, 16'h1234);
    op(3, 1, 0, 8'hA5); op(3, 0, 1, 8'h00);
    chk(mem_addr == 16'h1234, "R7 no step", mem_addr, 16'h1234);
    // R3 swapped order
    op(0, 1, 0, 8'h02);
    chk(mem_addr == 16'h3412, "R3 order B-high", mem_addr, 16'h3412);
    // R6 non-window reads
    op(0, 0, 1, 0); op(1, 0, 1, 0); op(2, 0, 1, 0);
    // R9 wrap
    op(0, 1, 0, 8'h03); op(1, 1, 0, 8'hFF); op(2, 1, 0, 8'hFF);
    op(3, 1, 0, 8'h5A);
    chk(mem_addr == 16'h0000, "R9 wrap", mem_addr, 16'h0000);
    // R8 write-back then swap
    op(0, 1, 0, 8'h01); op(1, 1, 0, 8'h12); op(2, 1, 0, 8'hFF);
    op(3, 0, 1, 0);
    chk(mem_addr == 16'h1300, "R7 step read", mem_addr, 16'h1300);
    op(0, 1, 0, 8'h03);
    chk(mem_addr == 16'h0013, "R8 write-back", mem_addr, 16'h0013);
    // R10 simultaneous
    op(3, 1, 1, 8'h77);
    chk(shadow_rd(16'h0013) == 8'h77, "R10 write taken", shadow_rd(16'h0013), 8'h77);
    op(0, 1, 0, 8'h00); op(1, 1, 0, 8'h00); op(2, 1, 0, 8'h13);
    op(3, 0, 1, 0);
    // random
    void'($urandom(32'd2024));
    for (int i = 0; i < 400; i++) begin
      logic [1:0] s;
      bit w, r;
      s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 6) s = 2'd3;
      w = $urandom_range(0, 1) != 0;
      r = $urandom_range(0, 3) != 0;
      if (s == 2'd1 || s == 2'd2) op(s, w, r, 8'($urandom_range(0, 3) == 0 ? 8'hFF : $urandom_range(0, 255)));
      else op(s, w, r, 8'($urandom_range(0, 255)));
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule